// File: doc/BRIEF.md
# Sv32 Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table that sits in main memory. A requester presents the address, a two-bit access tag and the current address-translation control word through a valid/ready handshake. The walker then reads one page table entry per level through a single-word memory read port. It returns a one-cycle response that carries one of three outcomes:

- the leaf entry with the physical address it maps to;
- a bare-mode pass-through;
- a "no mapping" flag.

A separate permission checker uses that response to decide which page fault to raise.

The walker checks the entry encoding, the alignment of a superpage and whether each table it is about to read lies inside the installed memory. It keeps no translation cache. It does not update accessed or dirty bits. It does not touch the target data.

Top module: `sv32_walker`

## Requirements
- R1: When bit 31 of `satp` is 0, translation is off. The response has `rsp_bare`=1, `rsp_fault`=0, `rsp_paddr` equal to the virtual address zero-extended to 34 bits and `rsp_pte`=0, and no memory read is issued.
- R2: When bit 31 of `satp` is 1, `satp[21:0]` is the root table page number and `satp[30:22]` is ignored. The first read is at root×4096 + VA[31:22]×4. After a pointer entry, the second read is at PTE[31:10]×4096 + VA[21:12]×4.
- R3: A leaf entry read at the second level gives `rsp_paddr` = {PTE[31:10], VA[11:0]}, with `rsp_fault`=0 and `rsp_super`=0.
- R4: The entry type is PTE[3:0] read as {X,W,R,V}. 0001 is a pointer. 0011, 0111, 1001, 1011 and 1111 are leaves. 0101 and 1101 are reserved, and any code with V=0 is invalid; both end the walk with `rsp_fault`=1, `rsp_paddr`=0 and `rsp_pte`=0.
- R5: A pointer entry found at the second level ends the walk with `rsp_fault`=1.
- R6: A leaf at the first level is a 4 MiB superpage. It gives `rsp_super`=1 and `rsp_paddr` = {PTE[31:20], VA[21:0]}. If PTE[19:10] is nonzero, the superpage is misaligned and the walk ends with `rsp_fault`=1.
- R7: A table whose page number is not below MEM_BYTES/4096 is never read. This holds for the root and for the next level, and the walk ends with `rsp_fault`=1. A leaf page number is not bound-checked.
- R8: `req_ready` is high only while idle. Each accepted request yields exactly one `rsp_valid` pulse of one cycle. `rsp_acc` echoes the request's access tag, and `rsp_pte` holds the leaf entry on success.
- R9: Each level issues one single-cycle `mem_req_valid` pulse. The walker waits any number of cycles for `mem_rsp_valid` before it evaluates that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access tag, passed to the response |
| satp | input | 32 | Translation control: mode bit 31, root page number in [21:0] |
| mem_req_valid | output | 1 | Page table entry read strobe |
| mem_req_addr | output | 34 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page table entry read |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_fault | output | 1 | No usable mapping |
| rsp_bare | output | 1 | Translation was off |
| rsp_super | output | 1 | Mapping is a superpage |
| rsp_paddr | output | 34 | Physical address |
| rsp_pte | output | 32 | Leaf entry |
| rsp_acc | output | 2 | Echoed access tag |

## Verification
The hardest outcomes to reach from the ports need a memory image that is consistent across both levels. Examples are a pointer whose target table lies just past the end of memory, and a pointer found at the second level. Random addresses alone almost never produce them. The bench therefore builds a fresh image for every trial. It places a biased random entry exactly where the first-level index points and, when that entry is a pointer, another entry where the second-level index points. Page numbers are drawn around the memory limit, and a directed set pins the exact boundary page and every reserved code. The memory model answers with random latency so that the wait state is exercised.

// File: rtl/sv32_walker.sv
module sv32_walker #(
  parameter longint unsigned MEM_BYTES = 64'd16777216
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic [31:0] satp,
  output logic        mem_req_valid,
  output logic [33:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic        rsp_bare,
  output logic        rsp_super,
  output logic [33:0] rsp_paddr,
  output logic [31:0] rsp_pte,
  output logic [1:0]  rsp_acc
);

  localparam longint unsigned NUM_PAGES = MEM_BYTES >> 12;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} st_t;

  st_t         st;
  logic [31:0] va_q;
  logic        lvl_q;
  logic [21:0] tbl_q;

  function automatic logic ppn_ok(input logic [21:0] p);
    return 64'(p) < NUM_PAGES;
  endfunction

  wire [3:0]  xwrv    = mem_rsp_data[3:0];
  wire        is_ptr  = xwrv == 4'b0001;
  wire        is_rsv  = xwrv[0] && xwrv[2] && !xwrv[1];
  wire        is_leaf = xwrv[0] && !is_ptr && !is_rsv;
  wire        misal   = lvl_q && (mem_rsp_data[19:10] != 10'd0);
  wire [9:0]  vpn     = lvl_q ? va_q[31:22] : va_q[21:12];
  wire        root_ok = ppn_ok(satp[21:0]);

  assign req_ready     = st == S_IDLE;
  assign rsp_valid     = st == S_DONE;
  assign mem_req_valid = st == S_FETCH;
  assign mem_req_addr  = {tbl_q, 12'b0} + {22'b0, vpn, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      lvl_q     <= 1'b1;
      tbl_q     <= '0;
      rsp_fault <= 1'b0;
      rsp_bare  <= 1'b0;
      rsp_super <= 1'b0;
      rsp_paddr <= '0;
      rsp_pte   <= '0;
      rsp_acc   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q      <= req_vaddr;
          rsp_acc   <= req_acc;
          lvl_q     <= 1'b1;
          tbl_q     <= satp[21:0];
          rsp_pte   <= '0;
          rsp_super <= 1'b0;
          rsp_bare  <= !satp[31];
          rsp_paddr <= satp[31] ? 34'd0 : {2'b00, req_vaddr};
          rsp_fault <= satp[31] && !root_ok;
          st        <= (satp[31] && root_ok) ? S_FETCH : S_DONE;
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (is_ptr && lvl_q && ppn_ok(mem_rsp_data[31:10])) begin
            tbl_q <= mem_rsp_data[31:10];
            lvl_q <= 1'b0;
            st    <= S_FETCH;
          end else begin
            st <= S_DONE;
            if (is_leaf && !misal) begin
              rsp_fault <= 1'b0;
              rsp_pte   <= mem_rsp_data;
              rsp_super <= lvl_q;
              rsp_paddr <= lvl_q ? {mem_rsp_data[31:20], va_q[21:0]}
                                 : {mem_rsp_data[31:10], va_q[11:0]};
            end else begin
              rsp_fault <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_bare_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bare |-> !rsp_fault && rsp_paddr[33:32] == 2'b00 && rsp_paddr[31:0] == va_q);

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == va_q[11:0]);

  a_r4_leaf_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && !rsp_bare |-> rsp_pte[0] && rsp_pte[3:1] != 3'b000 && !(rsp_pte[2] && !rsp_pte[1]));

  a_r6_super_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_super && !rsp_fault |-> rsp_pte[19:10] == 10'd0);

  a_r7_table_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> 64'(mem_req_addr) < MEM_BYTES);

  a_r8_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  a_r9_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

endmodule

// File: tb/tb_sv32_walker.sv
`timescale 1ns/1ps
module tb_sv32_walker;
  localparam longint unsigned MEM_BYTES = 64'd16777216;
  localparam int NPG = int'(MEM_BYTES >> 12);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic req_ready;
  logic [31:0] req_vaddr = 0; logic [1:0] req_acc = 0; logic [31:0] satp = 0;
  logic mem_req_valid; logic [33:0] mem_req_addr;
  logic mem_rsp_valid = 0; logic [31:0] mem_rsp_data = 0;
  logic rsp_valid, rsp_fault, rsp_bare, rsp_super;
  logic [33:0] rsp_paddr; logic [31:0] rsp_pte; logic [1:0] rsp_acc;

  always #2 clk = ~clk;

  sv32_walker #(.MEM_BYTES(MEM_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .satp(satp),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_bare(rsp_bare),
    .rsp_super(rsp_super), .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte), .rsp_acc(rsp_acc));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] pmem [longint unsigned];
  int nrd; logic [33:0] rd_log [4];
  logic pend = 0; int lat = 0; logic [33:0] pa_q = 0;

  function automatic logic [31:0] rd(input logic [33:0] a);
    longint unsigned k = 64'(a);
    return pmem.exists(k) ? pmem[k] : 32'd0;
  endfunction

  task automatic wr(input logic [33:0] a, input logic [31:0] d);
    if (64'(a) < MEM_BYTES) pmem[64'(a)] = d;
  endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic logic leafc(input logic [3:0] t);
    return t inside {4'b0011, 4'b0111, 4'b1001, 4'b1011, 4'b1111};
  endfunction

  task automatic model(input logic [31:0] va, input logic [31:0] sp,
                       output logic f, output logic b, output logic s,
                       output logic [33:0] pa, output logic [31:0] pte,
                       output int n, output logic [33:0] a0, output logic [33:0] a1);
    logic [31:0] p, q;
    f = 0; b = 0; s = 0; pa = 0; pte = 0; n = 0; a0 = 0; a1 = 0;
    if (!sp[31]) begin b = 1; pa = {2'b00, va}; return; end
    if (int'(sp[21:0]) >= NPG) begin f = 1; return; end
    a0 = {sp[21:0], 12'b0} + {22'b0, va[31:22], 2'b00}; n = 1; p = rd(a0);
    if (p[3:0] == 4'b0001) begin
      if (int'(p[31:10]) >= NPG) begin f = 1; return; end
      a1 = {p[31:10], 12'b0} + {22'b0, va[21:12], 2'b00}; n = 2; q = rd(a1);
      if (leafc(q[3:0])) begin pte = q; pa = {q[31:10], va[11:0]}; end
      else f = 1;
    end else if (leafc(p[3:0]) && p[19:10] == 10'd0) begin
      s = 1; pte = p; pa = {p[31:20], va[21:0]};
    end else f = 1;
  endtask

  always @(negedge clk) begin
    if (mem_req_valid) begin
      pend = 1; pa_q = mem_req_addr; lat = $urandom_range(1, 3);
      if (nrd < 4) rd_log[nrd] = mem_req_addr;
      nrd++;
      mem_rsp_valid = 0; mem_rsp_data = $urandom;
    end else if (pend) begin
      if (lat <= 1) begin mem_rsp_valid = 1; mem_rsp_data = rd(pa_q); pend = 0; end
      else begin lat--; mem_rsp_valid = 0; end
    end else begin
      mem_rsp_valid = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(input logic [31:0] va, input logic [31:0] sp, input string tag);
    logic f, b, s; logic [33:0] pa, a0, a1; logic [31:0] pte; int n, w;
    logic [1:0] acc = 2'($urandom);
    model(va, sp, f, b, s, pa, pte, n, a0, a1);
    @(negedge clk);
    nrd = 0;
    req_valid = 1; req_vaddr = va; satp = sp; req_acc = acc;
    @(negedge clk);
    req_valid = 0; satp = $urandom; req_vaddr = $urandom;
    w = 0;
    while (!rsp_valid && w < 100) begin @(negedge clk); w++; end
    chk({tag, " R8 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " fault"}, 64'(rsp_fault), 64'(f));
    chk("R1 bare", 64'(rsp_bare), 64'(b));
    chk("R6 super", 64'(rsp_super), 64'(s));
    chk({tag, " paddr"}, 64'(rsp_paddr), 64'(pa));
    chk("R8 pte", 64'(rsp_pte), 64'(pte));
    chk("R8 acc", 64'(rsp_acc), 64'(acc));
    chk("R9 reads", 64'(nrd), 64'(n));
    if (n >= 1) chk("R2 addr0", 64'(rd_log[0]), 64'(a0));
    if (n >= 2) chk("R2 addr1", 64'(rd_log[1]), 64'(a1));
    for (int i = 0; i < nrd && i < 4; i++)
      chk("R7 bound", 64'(64'(rd_log[i]) < MEM_BYTES), 64'd1);
    @(negedge clk);
    chk("R8 one pulse", 64'(rsp_valid), 64'd0);
  endtask

  function automatic logic [31:0] mkpte(input logic [21:0] ppn, input logic [3:0] c);
    return {ppn, 6'($urandom), c};
  endfunction

  localparam logic [31:0] VA = 32'h1234_5678;
  localparam logic [31:0] SP = 32'h8000_0005;
  localparam logic [33:0] E1 = 34'h5000 + 34'h48 * 4;

  initial begin
    void'($urandom(32'd20240611));
    nrd = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset ready", 64'(req_ready), 64'd1);
    chk("R8 reset rsp", 64'(rsp_valid), 64'd0);
    chk("R9 reset mem", 64'(mem_req_valid), 64'd0);
    rst_n = 1;

    pmem.delete(); run(VA, 32'h0000_0005, "R1");
    pmem.delete(); wr(E1, mkpte(22'd7, 4'b0001));
    wr(34'h7000 + 34'h345 * 4, mkpte(22'h3ABCD, 4'b1011)); run(VA, SP, "R3");
    pmem.delete(); wr(E1, mkpte(22'h2400, 4'b0111)); run(VA, SP, "R6 aligned");
    pmem.delete(); wr(E1, mkpte(22'h2401, 4'b0111)); run(VA, SP, "R6 misaligned");
    pmem.delete(); wr(E1, mkpte(22'd9, 4'b0101)); run(VA, SP, "R4 rsv0101");
    pmem.delete(); wr(E1, mkpte(22'd7, 4'b0001));
    wr(34'h7000 + 34'h345 * 4, mkpte(22'd3, 4'b1101)); run(VA, SP, "R4 rsv1101");
    pmem.delete(); wr(E1, mkpte(22'd9, 4'b1110)); run(VA, SP, "R4 invalid");
    pmem.delete(); wr(E1, mkpte(22'd7, 4'b0001));
    wr(34'h7000 + 34'h345 * 4, mkpte(22'd8, 4'b0001)); run(VA, SP, "R5");
    pmem.delete(); run(VA, 32'h8000_0000 | NPG, "R7 root oob");
    pmem.delete(); wr(E1, mkpte(22'(NPG), 4'b0001)); run(VA, SP, "R7 ptr oob");
    pmem.delete(); wr(E1, mkpte(22'(NPG - 1), 4'b0001));
    wr({22'(NPG - 1), 12'b0} + 34'h345 * 4, mkpte(22'h12, 4'b0011)); run(VA, SP, "R7 last page");

    for (int t = 0; t < 600; t++) begin
      logic [31:0] va, sp, p1; logic [21:0] root, pp; logic [3:0] c1; logic [33:0] a0;
      pmem.delete();
      va = $urandom;
      root = ($urandom_range(0, 15) == 0) ? 22'(NPG + $urandom_range(0, 3)) : 22'($urandom_range(0, NPG - 1));
      sp = {($urandom_range(0, 7) != 0), 9'($urandom), root};
      c1 = ($urandom_range(0, 1) == 0) ? 4'b0001 : 4'($urandom);
      if (c1 == 4'b0001)
        pp = ($urandom_range(0, 7) == 0) ? 22'(NPG + $urandom_range(0, 2)) : 22'($urandom_range(0, NPG - 1));
      else
        pp = ($urandom_range(0, 1) == 0) ? {12'($urandom), 10'd0} : 22'($urandom);
      p1 = mkpte(pp, c1);
      a0 = {root, 12'b0} + {22'b0, va[31:22], 2'b00};
      wr(a0, p1);
      if (c1 == 4'b0001)
        wr({pp, 12'b0} + {22'b0, va[21:12], 2'b00}, mkpte(22'($urandom), 4'($urandom)));
      run(va, sp, "R4 rand");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule